// File: doc/BRIEF.md
# Fast-Control Command Handler

This block sits behind the fast-control receiver of a pixel readout chip. It accepts five decoded command strobes on the 40 MHz bunch clock and turns them into actions. The actions are: a buffer flush that keeps the configuration, a preload of the bunch-crossing counter, a synchronisation check of that counter, a capture of the internal counters, and a request to send the test pattern. Its outputs feed the readout buffers, the serialiser pattern multiplexer and the slow-control register space.

The block keeps a 12-bit free-running bunch-crossing counter. A bunch-count reset loads the counter with a configurable offset. A sync command compares the counter with a configured expected value. On a mismatch the block latches the counter value and counts the error in a saturating counter. A front-end reset starts a flush that holds a busy output for a fixed number of cycles. While the flush runs, every command except bunch-count reset is dropped. When several strobes arrive in the same cycle, a fixed priority picks exactly one of them.

Top module: `fc_cmd_handler`

## Requirements
- R1: After reset the counter, the error count, the mismatch value, the snapshot outputs, `flush_busy` and the pattern outputs are all zero. An accepted `cmd_bx_rst` makes `bx_count` equal to `cfg_bx_offset` one cycle later. In every cycle without an accepted `cmd_bx_rst`, `bx_count` advances by one.
- R2: `bx_count` wraps from 4095 to 0.
- R3: An accepted `cmd_sync` compares the `bx_count` value seen at that clock edge with `cfg_sync_expect`. On a match nothing changes. On a mismatch, `sync_miss_bx` takes the counter value and `err_count` increases by one on the next cycle.
- R4: `err_count` is 8 bits wide and holds at 255. A pulse on `cfg_err_clr` sets it to 0 on the next cycle, and this clear takes precedence over a simultaneous increment.
- R5: An accepted `cmd_fe_rst` raises `flush_busy` on the next cycle and keeps it high for exactly 64 cycles. The flush leaves `err_count` and the counter sequence unchanged.
- R6: While `flush_busy` is high, `cmd_fe_rst`, `cmd_sync`, `cmd_snap` and `cmd_cal` have no effect: the flush is not extended, `err_count` does not move, `snap_valid` and `pat_sel` stay 0. `cmd_bx_rst` is still accepted during the flush.
- R7: An accepted `cmd_snap` pulses `snap_valid` high for one cycle. On that cycle `snap_bx` holds the counter value and `snap_err` holds the error count that were present at the command edge.
- R8: An accepted `cmd_cal` pulses `pat_sel` high for one cycle, with `pat_word` equal to `cfg_pattern`. Otherwise `pat_word` is zero.
- R9: Only one command acts in a given cycle. The order of precedence is `cmd_fe_rst` (when not busy), then `cmd_bx_rst`, then `cmd_sync`, then `cmd_snap`, then `cmd_cal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz bunch clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_fe_rst | input | 1 | Front-end reset strobe (buffer flush) |
| cmd_bx_rst | input | 1 | Bunch-count reset strobe (load offset) |
| cmd_sync | input | 1 | Synchronisation check strobe |
| cmd_snap | input | 1 | Snapshot strobe |
| cmd_cal | input | 1 | Calibration strobe (send test pattern) |
| cfg_bx_offset | input | 12 | Preload value for the bunch counter |
| cfg_sync_expect | input | 12 | Counter value expected at a sync command |
| cfg_err_clr | input | 1 | Configuration write strobe that clears the error count |
| cfg_pattern | input | 16 | Configurable test pattern |
| bx_count | output | 12 | Bunch-crossing counter |
| err_count | output | 8 | Saturating sync error count |
| sync_miss_bx | output | 12 | Counter value latched at the last failed sync |
| flush_busy | output | 1 | Buffer clear in progress |
| snap_valid | output | 1 | One-cycle capture strobe |
| snap_bx | output | 12 | Captured counter value |
| snap_err | output | 8 | Captured error count |
| pat_sel | output | 1 | Selects the test pattern on the serialisers |
| pat_word | output | 16 | Pattern to send while pat_sel is high |

## Verification
The bench builds the block with its default parameters: a 12-bit counter, an 8-bit error count, a 64-cycle flush and a 16-bit pattern. With these values the bench reaches the wrap by preloading an offset of 4094, and reaches saturation with a burst of 260 failed syncs. It checks both edges of the 64-cycle busy window and fires the other commands in the middle of a flush. Same-cycle strobe combinations exercise each step of the priority order.

// File: rtl/fc_pkg.sv
package fc_pkg;

  typedef enum logic [2:0] {
    FC_NONE  = 3'd0,
    FC_FLUSH = 3'd1,
    FC_LOAD  = 3'd2,
    FC_CHECK = 3'd3,
    FC_CAPT  = 3'd4,
    FC_PATT  = 3'd5
  } fc_cmd_e;

  // strobe vector bit order: [0] flush, [1] load, [2] check, [3] capture, [4] pattern
  localparam int unsigned FC_NCMD = 5;

  function automatic fc_cmd_e fc_pick(input logic [FC_NCMD-1:0] stb, input logic busy);
    fc_cmd_e sel;
    if (stb[0] && !busy)     sel = FC_FLUSH;
    else if (stb[1])         sel = FC_LOAD;
    else if (busy)           sel = FC_NONE;
    else if (stb[2])         sel = FC_CHECK;
    else if (stb[3])         sel = FC_CAPT;
    else if (stb[4])         sel = FC_PATT;
    else                     sel = FC_NONE;
    return sel;
  endfunction

endpackage

// File: rtl/fc_bx_counter.sv
module fc_bx_counter #(
  parameter int unsigned BX_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [BX_W-1:0] load_val,
  output logic [BX_W-1:0] count
);

  logic [BX_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load_en) cnt_d = load_val;
    else         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/fc_sync_check.sv
module fc_sync_check #(
  parameter int unsigned BX_W  = 12,
  parameter int unsigned ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             check_en,
  input  logic [BX_W-1:0]  bx_now,
  input  logic [BX_W-1:0]  bx_expect,
  input  logic             err_clr,
  output logic [ERR_W-1:0] err_count,
  output logic [BX_W-1:0]  miss_bx
);

  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

  logic             miss;
  logic             err_en, miss_en;
  logic [ERR_W-1:0] err_q, err_d;
  logic [BX_W-1:0]  miss_q;

  always_comb begin
    miss    = check_en && (bx_now != bx_expect);
    miss_en = miss;
    err_en  = err_clr || (miss && (err_q != ERR_MAX));
    err_d   = err_clr ? '0 : err_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= '0;
      miss_q <= '0;
    end else begin
      if (err_en)  err_q  <= err_d;
      if (miss_en) miss_q <= bx_now;
    end
  end

  assign err_count = err_q;
  assign miss_bx   = miss_q;

endmodule

// File: rtl/fc_flush_ctrl.sv
module fc_flush_ctrl #(
  parameter int unsigned FLUSH_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int unsigned CW = (FLUSH_CYC > 1) ? $clog2(FLUSH_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(FLUSH_CYC - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] left_q, left_d;

  always_comb begin
    busy_d = busy_q;
    left_d = left_q;
    if (start) begin
      busy_d = 1'b1;
      left_d = LAST;
    end else if (busy_q) begin
      if (left_q == '0) busy_d = 1'b0;
      else              left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else begin
      busy_q <= busy_d;
      left_q <= left_d;
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/fc_cmd_handler.sv
module fc_cmd_handler #(
  parameter int unsigned BX_W      = 12,
  parameter int unsigned ERR_W     = 8,
  parameter int unsigned FLUSH_CYC = 64,
  parameter int unsigned PAT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_fe_rst,
  input  logic             cmd_bx_rst,
  input  logic             cmd_sync,
  input  logic             cmd_snap,
  input  logic             cmd_cal,
  input  logic [BX_W-1:0]  cfg_bx_offset,
  input  logic [BX_W-1:0]  cfg_sync_expect,
  input  logic             cfg_err_clr,
  input  logic [PAT_W-1:0] cfg_pattern,
  output logic [BX_W-1:0]  bx_count,
  output logic [ERR_W-1:0] err_count,
  output logic [BX_W-1:0]  sync_miss_bx,
  output logic             flush_busy,
  output logic             snap_valid,
  output logic [BX_W-1:0]  snap_bx,
  output logic [ERR_W-1:0] snap_err,
  output logic             pat_sel,
  output logic [PAT_W-1:0] pat_word
);

  import fc_pkg::*;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  // command selection
  logic [FC_NCMD-1:0] stb;
  fc_cmd_e            cmd;
  logic               busy;

  always_comb begin
    stb = {cmd_cal, cmd_snap, cmd_sync, cmd_bx_rst, cmd_fe_rst};
    cmd = fc_pick(stb, busy);
  end

  fc_bx_counter #(.BX_W(BX_W)) u_bx (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load_en  (cmd == FC_LOAD),
    .load_val (cfg_bx_offset),
    .count    (bx_count)
  );

  fc_sync_check #(.BX_W(BX_W), .ERR_W(ERR_W)) u_sync (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .check_en  (cmd == FC_CHECK),
    .bx_now    (bx_count),
    .bx_expect (cfg_sync_expect),
    .err_clr   (cfg_err_clr),
    .err_count (err_count),
    .miss_bx   (sync_miss_bx)
  );

  fc_flush_ctrl #(.FLUSH_CYC(FLUSH_CYC)) u_flush (
    .clk   (clk),
    .rst_n (rst_core_n),
    .start (cmd == FC_FLUSH),
    .busy  (busy)
  );

  assign flush_busy = busy;

  // snapshot and pattern outputs
  logic             capt_en, patt_en;
  logic             snap_v_q;
  logic [BX_W-1:0]  snap_bx_q;
  logic [ERR_W-1:0] snap_err_q;
  logic             pat_q;
  logic [PAT_W-1:0] pat_word_q, pat_word_d;

  always_comb begin
    capt_en    = (cmd == FC_CAPT);
    patt_en    = (cmd == FC_PATT);
    pat_word_d = patt_en ? cfg_pattern : '0;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      snap_v_q   <= 1'b0;
      snap_bx_q  <= '0;
      snap_err_q <= '0;
      pat_q      <= 1'b0;
      pat_word_q <= '0;
    end else begin
      snap_v_q   <= capt_en;
      pat_q      <= patt_en;
      pat_word_q <= pat_word_d;
      if (capt_en) begin
        snap_bx_q  <= bx_count;
        snap_err_q <= err_count;
      end
    end
  end

  assign snap_valid = snap_v_q;
  assign snap_bx    = snap_bx_q;
  assign snap_err   = snap_err_q;
  assign pat_sel    = pat_q;
  assign pat_word   = pat_word_q;

endmodule

// File: rtl/fc_cmd_checker.sv
module fc_cmd_checker #(
  parameter int unsigned BX_W      = 12,
  parameter int unsigned ERR_W     = 8,
  parameter int unsigned FLUSH_CYC = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_fe_rst,
  input logic             cmd_bx_rst,
  input logic             cmd_sync,
  input logic             cmd_snap,
  input logic             cmd_cal,
  input logic [BX_W-1:0]  cfg_bx_offset,
  input logic             cfg_err_clr,
  input logic [BX_W-1:0]  bx_count,
  input logic [ERR_W-1:0] err_count,
  input logic [BX_W-1:0]  sync_miss_bx,
  input logic             flush_busy,
  input logic             snap_valid,
  input logic             pat_sel
);

  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

  int unsigned busy_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          busy_run <= 0;
    else if (flush_busy) busy_run <= busy_run + 1;
    else                 busy_run <= 0;
  end

  // R1
  bx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_bx_rst |=> bx_count == $past(bx_count) + 1'b1);

  // R1
  bx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_bx_rst && (flush_busy || !cmd_fe_rst)) |=> bx_count == $past(cfg_bx_offset));

  // R4
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == ERR_MAX && !cfg_err_clr) |=> err_count == ERR_MAX);

  // R4
  err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_clr |=> err_count == '0);

  // R5
  flush_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_busy) |-> busy_run == FLUSH_CYC);

  // R5
  flush_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= FLUSH_CYC);

  // R6
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_busy && !cfg_err_clr) |=> ($stable(err_count) && $stable(sync_miss_bx)
                                       && !snap_valid && !pat_sel));

  // R9
  snap_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_snap && (cmd_fe_rst || cmd_bx_rst || cmd_sync)) |=> !snap_valid);

  // R8
  cal_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_cal && !flush_busy && !cmd_fe_rst && !cmd_bx_rst && !cmd_sync && !cmd_snap)
      |=> pat_sel);

endmodule

bind fc_cmd_handler fc_cmd_checker #(
  .BX_W(BX_W), .ERR_W(ERR_W), .FLUSH_CYC(FLUSH_CYC)
) u_fc_chk (
  .clk           (clk),
  .rst_n         (rst_core_n),
  .cmd_fe_rst    (cmd_fe_rst),
  .cmd_bx_rst    (cmd_bx_rst),
  .cmd_sync      (cmd_sync),
  .cmd_snap      (cmd_snap),
  .cmd_cal       (cmd_cal),
  .cfg_bx_offset (cfg_bx_offset),
  .cfg_err_clr   (cfg_err_clr),
  .bx_count      (bx_count),
  .err_count     (err_count),
  .sync_miss_bx  (sync_miss_bx),
  .flush_busy    (flush_busy),
  .snap_valid    (snap_valid),
  .pat_sel       (pat_sel)
);

// File: tb/fc_cmd_handler_bench.sv
module fc_cmd_handler_bench;

  localparam int BX_W = 12, ERR_W = 8, FLUSH_CYC = 64, PAT_W = 16;
  localparam int BX_MOD = 1 << BX_W;

  localparam int O_BX = 0, O_ERR = 1, O_MISS = 2, O_BUSY = 3, O_SV = 4,
                 O_SBX = 5, O_SERR = 6, O_PSEL = 7, O_PWORD = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cmd_fe_rst, cmd_bx_rst, cmd_sync, cmd_snap, cmd_cal;
  logic [BX_W-1:0]  cfg_bx_offset, cfg_sync_expect;
  logic             cfg_err_clr;
  logic [PAT_W-1:0] cfg_pattern;
  logic [BX_W-1:0]  bx_count, sync_miss_bx, snap_bx;
  logic [ERR_W-1:0] err_count, snap_err;
  logic             flush_busy, snap_valid, pat_sel;
  logic [PAT_W-1:0] pat_word;

  always #5 clk = ~clk;

  fc_cmd_handler u_fc_cmd_handler (
    .clk(clk), .rst_n(rst_n),
    .cmd_fe_rst(cmd_fe_rst), .cmd_bx_rst(cmd_bx_rst), .cmd_sync(cmd_sync),
    .cmd_snap(cmd_snap), .cmd_cal(cmd_cal),
    .cfg_bx_offset(cfg_bx_offset), .cfg_sync_expect(cfg_sync_expect),
    .cfg_err_clr(cfg_err_clr), .cfg_pattern(cfg_pattern),
    .bx_count(bx_count), .err_count(err_count), .sync_miss_bx(sync_miss_bx),
    .flush_busy(flush_busy), .snap_valid(snap_valid), .snap_bx(snap_bx),
    .snap_err(snap_err), .pat_sel(pat_sel), .pat_word(pat_word)
  );

  typedef struct {
    int    due;
    int    sel;
    int    exp;
    string req;
  } exp_t;

  exp_t q[$];
  int   n_run = 0, n_fail = 0;
  int   cyc = 0;
  bit   done = 0;

  // bench-side reference: last accepted counter load
  int rst_due = 0, rst_off = 0;
  int err_ref = 0, miss_ref = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int exp_bx(input int t);
    return (rst_off + (t - rst_due)) % BX_MOD;
  endfunction

  function automatic int outv(input int sel);
    case (sel)
      O_BX:    return int'(bx_count);
      O_ERR:   return int'(err_count);
      O_MISS:  return int'(sync_miss_bx);
      O_BUSY:  return int'(flush_busy);
      O_SV:    return int'(snap_valid);
      O_SBX:   return int'(snap_bx);
      O_SERR:  return int'(snap_err);
      O_PSEL:  return int'(pat_sel);
      default: return int'(pat_word);
    endcase
  endfunction

  task automatic check(input int sel, input int exp, input string req);
    int act;
    act = outv(sel);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("[TB] FAIL %s: output %0d actual %0d expected %0d at cycle %0d",
               req, sel, act, exp, cyc);
    end
  endtask

  task automatic expect_at(input int due, input int sel, input int exp, input string req);
    exp_t e;
    e.due = due; e.sel = sel; e.exp = exp; e.req = req;
    q.push_back(e);
  endtask

  // monitor: compares every expected item as its cycle comes up
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        check(q[i].sel, q[i].exp, q[i].req);
        q.delete(i);
      end
    end
  end

  // driver: strobes for one clock edge; bit 0 fe, 1 bx, 2 sync, 3 snap, 4 cal
  task automatic drive(input logic [4:0] s);
    {cmd_cal, cmd_snap, cmd_sync, cmd_bx_rst, cmd_fe_rst} = s;
    @(negedge clk);
    {cmd_cal, cmd_snap, cmd_sync, cmd_bx_rst, cmd_fe_rst} = 5'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bx_load(input int off, input string req);
    cfg_bx_offset = BX_W'(off);
    rst_off = off; rst_due = cyc + 1;
    expect_at(cyc + 1, O_BX, off, req);
    drive(5'b00010);
  endtask

  task automatic sync_cmd(input bit hit, input bit chk, input string req);
    int now;
    now = exp_bx(cyc);
    cfg_sync_expect = hit ? BX_W'(now) : BX_W'(now ^ 1);
    if (!hit) begin
      miss_ref = now;
      if (err_ref < 255) err_ref++;
    end
    if (chk) begin
      expect_at(cyc + 1, O_ERR, err_ref, req);
      expect_at(cyc + 1, O_MISS, miss_ref, req);
    end
    drive(5'b00100);
  endtask

  task automatic finish_run();
    if (q.size() != 0) begin
      n_run++; n_fail++;
      $display("[TB] FAIL queue: actual %0d pending expected 0", q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    while (cyc < 20000 && !done) @(negedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("[TB] FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int c;
    rst_n = 1'b0;
    {cmd_cal, cmd_snap, cmd_sync, cmd_bx_rst, cmd_fe_rst} = 5'b0;
    cfg_bx_offset = '0; cfg_sync_expect = '0; cfg_err_clr = 1'b0; cfg_pattern = '0;
    idle(3);
    // R1: reset state
    check(O_BX, 0, "R1 reset"); check(O_ERR, 0, "R1 reset");
    check(O_BUSY, 0, "R1 reset"); check(O_SV, 0, "R1 reset");
    check(O_PSEL, 0, "R1 reset"); check(O_PWORD, 0, "R1 reset");
    rst_n = 1'b1;
    idle(4);

    // R1: load and count
    bx_load('h100, "R1 load");
    idle(4);
    expect_at(cyc + 1, O_BX, exp_bx(cyc + 1), "R1 count");
    idle(2);

    // R2: wrap
    bx_load(4094, "R2 load");
    expect_at(rst_due + 1, O_BX, 4095, "R2 top");
    expect_at(rst_due + 2, O_BX, 0, "R2 wrap");
    expect_at(rst_due + 3, O_BX, 1, "R2 after wrap");
    idle(4);

    // R3: match then mismatch
    sync_cmd(1'b1, 1'b1, "R3 match");
    idle(2);
    sync_cmd(1'b0, 1'b1, "R3 mismatch");
    idle(2);

    // R4: clear, then saturation
    cfg_err_clr = 1'b1; err_ref = 0;
    expect_at(cyc + 1, O_ERR, 0, "R4 clear");
    @(negedge clk); cfg_err_clr = 1'b0;
    for (int i = 0; i < 260; i++) sync_cmd(1'b0, 1'b0, "R4");
    expect_at(cyc, O_ERR, 255, "R4 saturate");
    @(negedge clk);
    sync_cmd(1'b0, 1'b1, "R4 hold at max");
    idle(2);
    // R4: clear wins over a simultaneous increment
    cfg_err_clr = 1'b1; err_ref = 0;
    cfg_sync_expect = BX_W'(exp_bx(cyc) ^ 1);
    expect_at(cyc + 1, O_ERR, 0, "R4 clear over increment");
    {cmd_sync} = 1'b1;
    @(negedge clk);
    cmd_sync = 1'b0; cfg_err_clr = 1'b0;
    miss_ref = exp_bx(cyc - 1);
    idle(2);

    // R7: snapshot
    sync_cmd(1'b0, 1'b1, "R3 mismatch before snapshot");
    expect_at(cyc + 1, O_SV, 1, "R7 valid");
    expect_at(cyc + 1, O_SBX, exp_bx(cyc), "R7 counter");
    expect_at(cyc + 1, O_SERR, err_ref, "R7 errors");
    expect_at(cyc + 2, O_SV, 0, "R7 one cycle");
    drive(5'b01000);
    idle(2);

    // R8: calibration
    cfg_pattern = 16'hA5C3;
    expect_at(cyc + 1, O_PSEL, 1, "R8 select");
    expect_at(cyc + 1, O_PWORD, 'hA5C3, "R8 word");
    expect_at(cyc + 2, O_PSEL, 0, "R8 one cycle");
    expect_at(cyc + 2, O_PWORD, 0, "R8 idle word");
    drive(5'b10000);
    idle(2);

    // R5 / R6: flush window and ignored commands
    c = cyc;
    expect_at(c + 1, O_BUSY, 1, "R5 rise");
    expect_at(c + FLUSH_CYC, O_BUSY, 1, "R5 last busy cycle");
    expect_at(c + FLUSH_CYC + 1, O_BUSY, 0, "R5 fall");
    expect_at(c + FLUSH_CYC + 1, O_ERR, err_ref, "R5 config kept");
    drive(5'b00001);
    idle(2);
    cfg_sync_expect = BX_W'(exp_bx(cyc) ^ 1);
    expect_at(cyc + 1, O_ERR, err_ref, "R6 sync ignored");
    expect_at(cyc + 1, O_MISS, miss_ref, "R6 sync ignored");
    drive(5'b00100);
    expect_at(cyc + 1, O_SV, 0, "R6 snapshot ignored");
    drive(5'b01000);
    expect_at(cyc + 1, O_PSEL, 0, "R6 calibration ignored");
    drive(5'b10000);
    drive(5'b00001); // R6: second flush request must not extend the window
    idle(2);
    bx_load('h200, "R6 load during flush");
    expect_at(cyc + 3, O_BX, exp_bx(cyc + 3), "R5 counter runs during flush");
    while (cyc < c + FLUSH_CYC + 4) @(negedge clk);

    // R9: priority combinations
    cfg_bx_offset = BX_W'('h300);
    cfg_sync_expect = BX_W'(exp_bx(cyc) ^ 1);
    rst_off = 'h300; rst_due = cyc + 1;
    expect_at(cyc + 1, O_BX, 'h300, "R9 load over sync");
    expect_at(cyc + 1, O_ERR, err_ref, "R9 load over sync");
    drive(5'b00110);
    idle(1);
    cfg_sync_expect = BX_W'(exp_bx(cyc) ^ 1);
    if (err_ref < 255) err_ref++;
    expect_at(cyc + 1, O_ERR, err_ref, "R9 sync over snapshot");
    expect_at(cyc + 1, O_SV, 0, "R9 sync over snapshot");
    drive(5'b01100);
    idle(1);
    expect_at(cyc + 1, O_SV, 1, "R9 snapshot over calibration");
    expect_at(cyc + 1, O_PSEL, 0, "R9 snapshot over calibration");
    drive(5'b11000);
    idle(1);
    cfg_bx_offset = BX_W'('h7);
    expect_at(cyc + 1, O_BUSY, 1, "R9 flush over load");
    expect_at(cyc + 1, O_BX, exp_bx(cyc + 1), "R9 flush over load");
    drive(5'b00011);
    idle(FLUSH_CYC + 2);
    cfg_sync_expect = BX_W'(exp_bx(cyc) ^ 1);
    expect_at(cyc + 1, O_BUSY, 1, "R9 flush over all");
    expect_at(cyc + 1, O_BX, exp_bx(cyc + 1), "R9 flush over all");
    expect_at(cyc + 1, O_ERR, err_ref, "R9 flush over all");
    expect_at(cyc + 1, O_SV, 0, "R9 flush over all");
    expect_at(cyc + 1, O_PSEL, 0, "R9 flush over all");
    drive(5'b11111);
    idle(FLUSH_CYC + 3);

    done = 1;
    finish_run();
  end

endmodule